// File: doc/BRIEF.md
# Analog/Digital Shared Pin Multiplexer

This block decides, pin by pin, whether each of ten shared package pins serves an analog converter/comparator input or a plain digital I/O line. Six pins are analog-only and stay in that role whatever software writes. The other four each carry one numbered digital line (lines 2, 4, 6 and 12). Each of these four can be switched between its analog role and its digital role.

Software programs the block through a small synchronous register slave with three registers. The mode register holds one 2-bit field per line number. Only the upper (odd) bit of a field acts, and a value of 0 selects digital. The direction register and the data register each hold one bit per digital line, at the bit position equal to the line number. The block drives an output enable and an output level for every pin, raises a per-pin analog-path enable, and returns the live pin levels of digital inputs through the data register. Out of reset every pin is analog and every digital driver is off.

Top module: `amux_bank`

## Requirements
- R1: After reset every `ana_en` bit is 1, `pin_oe` and `pin_out` are all 0, the mode register reads 0x02002220, and the data and direction registers read 0.
- R2: Pins 0, 2, 5, 6, 7 and 9 are analog-only. Their `ana_en` bit is always 1 and their `pin_oe` and `pin_out` bits are always 0, whatever is written.
- R3: The digital lines 2, 4, 6 and 12 sit on pins 1, 3, 4 and 8. Line n is steered by mode bit 2n+1: a 0 makes the pin digital (`ana_en` = 0), and a 1 makes it analog (`ana_en` = 1).
- R4: All mode register bits other than 5, 9, 13 and 25, which includes every even bit, ignore writes and read as 0.
- R5: A digital-capable pin's `pin_oe` is 1 only when its mode bit is 0 and its direction bit is 1. Its `pin_out` equals its data bit while `pin_oe` is 1, and is 0 otherwise.
- R6: Reading data bit n (n in 2, 4, 6, 12) returns 0 if line n is in analog mode, the last written data bit if it is a digital output, and the current `pin_in` level of its pin if it is a digital input.
- R7: Direction (1 = output) and data keep only bits 2, 4, 6 and 12. All other bits ignore writes and read as 0.
- R8: Register addresses are 0 mode, 1 data, 2 direction. Address 3 reads 0, and a write to it changes nothing.
- R9: A write takes effect on the clock edge where `reg_we` is sampled high and not before. Reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| pin_in | input | 10 | Sampled pin levels |
| pin_oe | output | 10 | Per-pin output enable |
| pin_out | output | 10 | Per-pin output level |
| ana_en | output | 10 | Per-pin analog path enable |

## Verification
The bench builds the block with its default 2-bit address and 32-bit data word. That width places every meaningful bit, including mode bit 25 for line 12, inside a single write. All-ones and even-bit-only patterns can therefore hit every ignored position in one access. With only four digital lines, every mixed combination of analog, digital-input and digital-output roles that the data read path distinguishes is reached with a few writes.

// File: rtl/amux_pkg.sv
package amux_pkg;

    localparam int NPIN = 10;
    localparam int NDIG = 4;

    // digital line number and the pin that carries it, per digital index
    localparam int DIG_SIG [NDIG] = '{2, 4, 6, 12};
    localparam int DIG_PIN [NDIG] = '{1, 3, 4, 8};

    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_DIR  = 2'd2;

    typedef struct packed {
        logic [NDIG-1:0] mode;  // 1 = analog
        logic [NDIG-1:0] dir;   // 1 = output
        logic [NDIG-1:0] dout;
    } cfg_t;

    // digital index carried by a pin, or -1 for an analog-only pin
    function automatic int pin_dig_idx(input int p);
        int r;
        r = -1;
        for (int i = 0; i < NDIG; i++) begin
            if (DIG_PIN[i] == p) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/amux_regs.sv
module amux_regs
    import amux_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg_q
);

    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                ADDR_W'(A_MODE): begin
                    for (int i = 0; i < NDIG; i++) begin
                        cfg_d.mode[i] = wdata[2*DIG_SIG[i]+1];
                    end
                end
                ADDR_W'(A_DATA): begin
                    for (int i = 0; i < NDIG; i++) begin
                        cfg_d.dout[i] = wdata[DIG_SIG[i]];
                    end
                end
                ADDR_W'(A_DIR): begin
                    for (int i = 0; i < NDIG; i++) begin
                        cfg_d.dir[i] = wdata[DIG_SIG[i]];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mode <= '1;
            cfg_q.dir  <= '0;
            cfg_q.dout <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/amux_pin_route.sv
module amux_pin_route (
    input  logic mode,
    input  logic dir,
    input  logic dout,
    input  logic pad_in,
    output logic oe,
    output logic out,
    output logic ana,
    output logic rd
);

    always_comb begin
        ana = mode;
        oe  = !mode && dir;
        out = oe && dout;
        if (mode)     rd = 1'b0;
        else if (dir) rd = dout;
        else          rd = pad_in;
    end

endmodule

// File: rtl/amux_rdmux.sv
module amux_rdmux
    import amux_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  cfg_t              cfg,
    input  logic [NDIG-1:0]   dig_rd,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(A_MODE): begin
                for (int i = 0; i < NDIG; i++) rdata[2*DIG_SIG[i]+1] = cfg.mode[i];
            end
            ADDR_W'(A_DATA): begin
                for (int i = 0; i < NDIG; i++) rdata[DIG_SIG[i]] = dig_rd[i];
            end
            ADDR_W'(A_DIR): begin
                for (int i = 0; i < NDIG; i++) rdata[DIG_SIG[i]] = cfg.dir[i];
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/amux_bank.sv
module amux_bank
    import amux_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   ana_en
);

    cfg_t            cfg_q;
    logic [NPIN-1:0] pin_rd;
    logic [NDIG-1:0] dig_rd;

    amux_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (reg_addr),
        .we    (reg_we),
        .wdata (reg_wdata),
        .cfg_q (cfg_q)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        localparam int DI = pin_dig_idx(p);
        if (DI >= 0) begin : g_dig
            amux_pin_route u_route (
                .mode   (cfg_q.mode[DI]),
                .dir    (cfg_q.dir[DI]),
                .dout   (cfg_q.dout[DI]),
                .pad_in (pin_in[p]),
                .oe     (pin_oe[p]),
                .out    (pin_out[p]),
                .ana    (ana_en[p]),
                .rd     (pin_rd[p])
            );
        end else begin : g_ana
            assign pin_oe[p]  = 1'b0;
            assign pin_out[p] = 1'b0;
            assign ana_en[p]  = 1'b1;
            assign pin_rd[p]  = 1'b0;
        end
    end

    for (genvar i = 0; i < NDIG; i++) begin : g_gather
        assign dig_rd[i] = pin_rd[DIG_PIN[i]];
    end

    amux_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
        .addr   (reg_addr),
        .cfg    (cfg_q),
        .dig_rd (dig_rd),
        .rdata  (reg_rdata)
    );

endmodule

// File: rtl/amux_bank_chk.sv
module amux_bank_chk
    import amux_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NPIN-1:0]   pin_in,
    input logic [NPIN-1:0]   pin_oe,
    input logic [NPIN-1:0]   pin_out,
    input logic [NPIN-1:0]   ana_en
);

    logic [NPIN-1:0] only_ana;
    logic [NDIG-1:0] ana_dig;
    logic [NDIG-1:0] wmode;

    always_comb begin
        only_ana = '1;
        for (int i = 0; i < NDIG; i++) begin
            only_ana[DIG_PIN[i]] = 1'b0;
            ana_dig[i] = ana_en[DIG_PIN[i]];
            wmode[i]   = reg_wdata[2*DIG_SIG[i]+1];
        end
    end

    AST_RESET_ANALOG: assert property (@(posedge clk)
        !rst_n |=> (ana_en == '1 && pin_oe == '0 && pin_out == '0)); // R1

    AST_ANALOG_ONLY_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ana_en & only_ana) == only_ana) && ((pin_oe & only_ana) == '0)); // R2

    AST_NO_DRIVE_IN_ANALOG: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ana_en) == '0); // R5

    AST_OUT_ONLY_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0); // R5

    AST_MODE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(A_MODE)) |=> ana_dig == $past(wmode)); // R3

    AST_UNUSED_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(3)) |-> reg_rdata == '0); // R8

    AST_UNUSED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(3)) |=> ($stable(ana_en) && $stable(pin_oe))); // R8

endmodule

bind amux_bank amux_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_amux_bank.sv
`timescale 1ns/1ps
module test_amux_bank;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  reg_addr = 0;
    logic        reg_we = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic [9:0]  pin_in = 0;
    logic [9:0]  pin_oe, pin_out, ana_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model of the requirements
    int  sig_n [4] = '{2, 4, 6, 12};
    int  pin_n [4] = '{1, 3, 4, 8};
    logic [3:0] m_mode = 4'hF, m_dir = 0, m_dout = 0;

    always #5 clk = ~clk;

    amux_bank i_amux_bank (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] e_ana();
        logic [9:0] v = '1;
        for (int i = 0; i < 4; i++) v[pin_n[i]] = m_mode[i];
        return v;
    endfunction
    function automatic logic [9:0] e_oe();
        logic [9:0] v = '0;
        for (int i = 0; i < 4; i++) v[pin_n[i]] = !m_mode[i] && m_dir[i];
        return v;
    endfunction
    function automatic logic [9:0] e_out();
        logic [9:0] v = '0;
        for (int i = 0; i < 4; i++) v[pin_n[i]] = !m_mode[i] && m_dir[i] && m_dout[i];
        return v;
    endfunction
    function automatic logic [31:0] e_data();
        logic [31:0] v = '0;
        for (int i = 0; i < 4; i++)
            v[sig_n[i]] = m_mode[i] ? 1'b0 : (m_dir[i] ? m_dout[i] : pin_in[pin_n[i]]);
        return v;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1;
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            if (a == 0) m_mode[i] = d[2*sig_n[i]+1];
            if (a == 1) m_dout[i] = d[sig_n[i]];
            if (a == 2) m_dir[i]  = d[sig_n[i]];
        end
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic chk_pins(input string tag);
        chk({tag, " ana_en"}, 32'(ana_en), 32'(e_ana()));
        chk({tag, " pin_oe"}, 32'(pin_oe), 32'(e_oe()));
        chk({tag, " pin_out"}, 32'(pin_out), 32'(e_out()));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 ana_en", 32'(ana_en), 32'h3FF);
        chk("R1 pin_oe", 32'(pin_oe), 0);
        chk("R1 pin_out", 32'(pin_out), 0);
        rd(0, d); chk("R1 mode read", d, 32'h0200_2220);
        rd(1, d); chk("R1 data read", d, 0);
        rd(2, d); chk("R1 dir read", d, 0);
    endtask

    task automatic t_mode_select();
        logic [31:0] d;
        wr(0, 32'hFFFF_FFDF);
        chk_pins("R3 line2 digital");
        chk("R3 pin1 only", 32'(ana_en), 32'h3FD);
        rd(0, d); chk("R4 mode readback", d, 32'h0200_2200);
        wr(0, 32'h5555_5555);
        chk("R3 all digital", 32'(ana_en), 32'h2E5);
        rd(0, d); chk("R4 even bits read 0", d, 0);
    endtask

    task automatic t_analog_only();
        wr(2, 32'hFFFF_FFFF);
        wr(1, 32'hFFFF_FFFF);
        chk("R2 oe on digital pins only", 32'(pin_oe), 32'h11A);
        chk("R2 out on digital pins only", 32'(pin_out), 32'h11A);
        chk("R2 analog-only ana_en", 32'(ana_en & 10'h2E5), 32'h2E5);
    endtask

    task automatic t_ignored_bits();
        logic [31:0] d;
        rd(2, d); chk("R7 dir keeps 4 bits", d, 32'h1054);
        rd(1, d); chk("R7 data keeps 4 bits", d, 32'h1054);
    endtask

    task automatic t_output_drive();
        wr(2, 32'h1054);
        wr(1, 32'h0014);
        chk_pins("R5 two high");
        chk("R5 out lines 2,4", 32'(pin_out), 32'h00A);
        wr(2, 32'h0004);
        chk("R5 oe line2 only", 32'(pin_oe), 32'h002);
        chk_pins("R5 dir mix");
        wr(0, 32'hFFFF_FFFF);
        chk("R5 analog kills oe", 32'(pin_oe), 0);
    endtask

    task automatic t_data_read();
        logic [31:0] d;
        wr(0, 32'h0200_2000);
        wr(2, 32'h0004);
        wr(1, 32'h1054);
        @(negedge clk); pin_in = 10'h3FF;
        rd(1, d); chk("R6 mixed, pins high", d, e_data());
        chk("R6 mixed value", d, 32'h14);
        @(negedge clk); pin_in = 10'h000;
        rd(1, d); chk("R6 mixed, pins low", d, 32'h04);
        chk_pins("R6 pins");
    endtask

    task automatic t_unused_addr();
        logic [31:0] d;
        logic [9:0] a0;
        a0 = ana_en;
        wr(3, 32'hFFFF_FFFF);
        chk("R8 addr3 write inert", 32'(ana_en), 32'(a0));
        rd(3, d); chk("R8 addr3 reads 0", d, 0);
        rd(2, d); chk("R8 dir unchanged", d, 32'h0004);
        rd(0, d); chk("R8 mode unchanged", d, 32'h0200_2000);
    endtask

    task automatic t_timing();
        @(negedge clk);
        reg_addr = 0; reg_wdata = 32'hFFFF_FFFF; reg_we = 1;
        #1 chk("R9 no effect before edge", 32'(ana_en), 32'(e_ana()));
        @(posedge clk);
        m_mode = 4'hF;
        #1 chk("R9 effect after edge", 32'(ana_en), 32'h3FF);
        @(negedge clk); reg_we = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        t_reset();
        t_mode_select();
        t_analog_only();
        t_ignored_bits();
        t_output_drive();
        t_data_read();
        t_unused_addr();
        t_timing();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule